// File: doc/BRIEF.md
# Parallel Slave Port

A byte-wide slave port through which an external host reads and writes one data register of an on-chip controller. The host uses three active-low strobes: select, write and read. None of them is related to the internal clock. Each strobe passes through a synchroniser before any decision is made on it.

Two latches sit behind the single internal address. An input latch holds the last byte the host wrote. An output latch holds the byte the controller last wrote for the host to fetch. A host write becomes visible to the controller only when the host ends it by raising either strobe. At that point a buffer-full flag and a one-cycle interrupt pulse are raised together. If the host completes another write before the controller has fetched the previous byte, an overrun flag is also set.

While the port is disabled the external strobes have no effect. The block then captures nothing, raises no flags and does not drive the bus.

Top module: `pslv_port`

## Requirements
- R1: After reset, `in_full`, `ovf_flag`, `irq_pulse` and `ext_data_oe` are 0, and both `cpu_rdata` and `ext_data_out` read 0x00.
- R2: A host write is active while `ext_cs_n` and `ext_wr_n` are both low. The byte on `ext_data_in` during that time is stored in the input latch and appears on `cpu_rdata`.
- R3: `in_full` stays 0 while the write strobes are held low. It becomes 1 within four clock cycles after the first of `ext_cs_n` or `ext_wr_n` returns high, whichever strobe rises first.
- R4: `irq_pulse` is high for exactly one cycle per completed host write, in the same cycle in which the flags are updated.
- R5: Once set, `in_full` is cleared only by a one-cycle `cpu_rd_in` pulse; clearing the overrun flag does not clear it.
- R6: A host write that completes while `in_full` is 1 sets `ovf_flag`. The new byte still replaces the old one in the input latch.
- R7: `ovf_flag` is cleared only by `cpu_ovf_clr`. A read of the input latch leaves it set.
- R8: `cpu_wr_out` loads `cpu_wdata` into the output latch, which is presented on `ext_data_out`. `ext_data_oe` is 1 only while the host holds `ext_cs_n` and `ext_rd_n` low, and returns to 0 within four cycles of their release.
- R9: While `port_en` is 0, host strobes are ignored. No byte is captured, no flag or pulse is raised, and `ext_data_oe` stays 0.
- R10: A strobe with only one of `ext_cs_n` and `ext_wr_n` low is not a write. It leaves the input latch, `in_full` and `irq_pulse` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Enables the port; when 0 host strobes are ignored |
| ext_cs_n | input | 1 | Host select, active low, asynchronous |
| ext_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| ext_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| ext_data_in | input | DATA_W | Byte driven by the host during a write |
| ext_data_out | output | DATA_W | Output latch contents toward the host |
| ext_data_oe | output | 1 | Bus drive enable for `ext_data_out` |
| cpu_wr_out | input | 1 | Internal write of the output latch |
| cpu_wdata | input | DATA_W | Internal write data |
| cpu_rd_in | input | 1 | Internal read of the input latch; clears `in_full` |
| cpu_ovf_clr | input | 1 | Internal clear of the overrun flag |
| cpu_rdata | output | DATA_W | Input latch contents |
| in_full | output | 1 | Buffer-full flag |
| ovf_flag | output | 1 | Overrun flag |
| irq_pulse | output | 1 | One-cycle pulse per completed host write |

## Verification
The hardest state to reach is an overrun. It needs a complete host write, then no internal read for the whole length of a second host write, and then the second completion, which lands several cycles after the strobe release because of the synchroniser. The bench gets there by performing one write and deliberately withholding `cpu_rd_in` and pulsing `cpu_ovf_clr`. It then completes a second write with a different byte and checks that the new byte replaced the old one while both flags are set. It also checks that a later read clears only the buffer-full flag.

// File: rtl/psp_pkg.sv
package psp_pkg;
   // Decoded host activity, all in the internal clock domain
   typedef struct packed {
      logic wr_busy;   // host write in progress
      logic wr_done;   // host write just ended
      logic rd_busy;   // host read in progress
   } psp_evt_t;

   localparam int STB_CS = 2;
   localparam int STB_WR = 1;
   localparam int STB_RD = 0;
   localparam int STB_N  = 3;
endpackage

// File: rtl/psp_sync.sv
module psp_sync #(
   parameter int   WIDTH   = 1,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("psp_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("psp_sync: WIDTH must be at least 1");
      end
   endgenerate

   genvar b;
   generate
      for (b = 0; b < WIDTH; b++) begin : g_bit
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[STAGES-2:0], d[b]};
         end
         assign q[b] = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/psp_strobe_det.sv
module psp_strobe_det
   import psp_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             port_en,
   input  logic [STB_N-1:0] stb_s,
   output psp_evt_t         evt
);
   logic sel;
   logic wr_low;
   logic rd_low;
   logic wr_prev;

   assign sel    = ~stb_s[STB_CS];
   assign wr_low = sel & ~stb_s[STB_WR];
   assign rd_low = sel & ~stb_s[STB_RD];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_prev <= 1'b0;
      else        wr_prev <= port_en & wr_low;
   end

   always_comb begin
      evt         = '0;
      evt.wr_busy = port_en & wr_low;
      evt.wr_done = port_en & wr_prev & ~wr_low;
      evt.rd_busy = port_en & rd_low;
   end
endmodule

// File: rtl/psp_latches.sv
module psp_latches
   import psp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  psp_evt_t          evt,
   input  logic [DATA_W-1:0] host_d,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_d,
   output logic [DATA_W-1:0] in_q,
   output logic [DATA_W-1:0] out_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           in_q <= '0;
      else if (evt.wr_busy) in_q <= host_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      out_q <= '0;
      else if (cpu_wr) out_q <= cpu_d;
   end
endmodule

// File: rtl/psp_flags.sv
module psp_flags
   import psp_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  psp_evt_t evt,
   input  logic     cpu_rd,
   input  logic     ovf_clr,
   output logic     full_q,
   output logic     ovf_q,
   output logic     irq_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         ovf_q  <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= evt.wr_done;
         if (evt.wr_done)  full_q <= 1'b1;
         else if (cpu_rd)  full_q <= 1'b0;
         if (evt.wr_done && full_q) ovf_q <= 1'b1;
         else if (ovf_clr)          ovf_q <= 1'b0;
      end
   end
endmodule

// File: rtl/pslv_port.sv
module pslv_port
   import psp_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic              ext_cs_n,
   input  logic              ext_wr_n,
   input  logic              ext_rd_n,
   input  logic [DATA_W-1:0] ext_data_in,
   output logic [DATA_W-1:0] ext_data_out,
   output logic              ext_data_oe,
   input  logic              cpu_wr_out,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              cpu_rd_in,
   input  logic              cpu_ovf_clr,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              in_full,
   output logic              ovf_flag,
   output logic              irq_pulse
);
   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("pslv_port: DATA_W must be positive");
      end
   endgenerate

   logic [STB_N-1:0] stb_raw;
   logic [STB_N-1:0] stb_s;
   psp_evt_t         evt;

   assign stb_raw[STB_CS] = ext_cs_n;
   assign stb_raw[STB_WR] = ext_wr_n;
   assign stb_raw[STB_RD] = ext_rd_n;

   psp_sync #(.WIDTH(STB_N), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(stb_raw), .q(stb_s)
   );

   psp_strobe_det u_det (
      .clk(clk), .rst_n(rst_n), .port_en(port_en), .stb_s(stb_s), .evt(evt)
   );

   psp_latches #(.DATA_W(DATA_W)) u_lat (
      .clk(clk), .rst_n(rst_n), .evt(evt), .host_d(ext_data_in),
      .cpu_wr(cpu_wr_out), .cpu_d(cpu_wdata),
      .in_q(cpu_rdata), .out_q(ext_data_out)
   );

   psp_flags u_flg (
      .clk(clk), .rst_n(rst_n), .evt(evt), .cpu_rd(cpu_rd_in),
      .ovf_clr(cpu_ovf_clr), .full_q(in_full), .ovf_q(ovf_flag),
      .irq_q(irq_pulse)
   );

   assign ext_data_oe = evt.rd_busy;
endmodule

// File: rtl/psp_chk.sv
module psp_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              port_en,
   input logic [DATA_W-1:0] ext_data_out,
   input logic              ext_data_oe,
   input logic              cpu_wr_out,
   input logic              cpu_rd_in,
   input logic              cpu_ovf_clr,
   input logic              in_full,
   input logic              ovf_flag,
   input logic              irq_pulse
);
   // R4
   full_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_full) |-> irq_pulse);
   // R4
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |=> !irq_pulse);
   // R5
   full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_full) |-> $past(cpu_rd_in));
   // R6
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> (irq_pulse && $past(in_full)));
   // R7
   ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovf_flag) |-> $past(cpu_ovf_clr));
   // R8
   out_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ext_data_out) |-> $past(cpu_wr_out));
   // R9
   no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |-> !ext_data_oe);
endmodule

bind pslv_port psp_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .port_en(port_en),
   .ext_data_out(ext_data_out), .ext_data_oe(ext_data_oe),
   .cpu_wr_out(cpu_wr_out), .cpu_rd_in(cpu_rd_in),
   .cpu_ovf_clr(cpu_ovf_clr), .in_full(in_full),
   .ovf_flag(ovf_flag), .irq_pulse(irq_pulse)
);

// File: tb/sim_pslv_port.sv
module sim_pslv_port;
   localparam int PERIOD = 10;
   localparam int W      = 8;
   // bit 8: select strobe rises first; bits 7:0: byte
   localparam logic [8:0] VEC [6] = '{9'h0A5, 9'h15A, 9'h000, 9'h1FF, 9'h03C, 9'h181};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic port_en = 1'b1;
   logic ext_cs_n = 1'b1, ext_wr_n = 1'b1, ext_rd_n = 1'b1;
   logic [W-1:0] ext_data_in = '0;
   logic [W-1:0] ext_data_out;
   logic ext_data_oe;
   logic cpu_wr_out = 1'b0;
   logic [W-1:0] cpu_wdata = '0;
   logic cpu_rd_in = 1'b0, cpu_ovf_clr = 1'b0;
   logic [W-1:0] cpu_rdata;
   logic in_full, ovf_flag, irq_pulse;

   int checks = 0, failures = 0, irq_cnt = 0;
   bit finished = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   pslv_port #(.DATA_W(W)) u0 (.*);

   always @(negedge clk) if (irq_pulse) irq_cnt++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr_begin(input logic [W-1:0] d);
      @(negedge clk);
      ext_data_in = d; ext_cs_n = 1'b0; ext_wr_n = 1'b0;
      cyc(5);
   endtask

   task automatic wr_end(input logic cs_first);
      if (cs_first) ext_cs_n = 1'b1; else ext_wr_n = 1'b1;
      cyc(1);
      ext_cs_n = 1'b1; ext_wr_n = 1'b1;
      cyc(4);
   endtask

   task automatic cpu_read();
      @(negedge clk); cpu_rd_in = 1'b1;
      @(negedge clk); cpu_rd_in = 1'b0;
   endtask

   initial begin
      #(PERIOD*200000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int base;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R1 reset state
      chk("R1 in_full", in_full, 0);
      chk("R1 ovf", ovf_flag, 0);
      chk("R1 oe", ext_data_oe, 0);
      chk("R1 rdata", cpu_rdata, 0);
      chk("R1 dout", ext_data_out, 0);
      chk("R1 irq", irq_cnt, 0);

      // Table walk: R2 R3 R4 R5
      foreach (VEC[i]) begin
         base = irq_cnt;
         wr_begin(VEC[i][7:0]);
         chk("R3 held low", in_full, 0);
         wr_end(VEC[i][8]);
         chk("R3 full set", in_full, 1);
         chk("R4 one pulse", irq_cnt, base + 1);
         chk("R2 byte", cpu_rdata, {24'd0, VEC[i][7:0]});
         cpu_read();
         chk("R5 cleared", in_full, 0);
         chk("R6 no ovf", ovf_flag, 0);
      end

      // R5 only a read clears; R6 overrun; R7 clear
      wr_begin(8'h11); wr_end(1'b0);
      cyc(10);
      chk("R5 stays", in_full, 1);
      @(negedge clk); cpu_ovf_clr = 1'b1; @(negedge clk); cpu_ovf_clr = 1'b0;
      chk("R5 ovf_clr no effect", in_full, 1);
      wr_begin(8'h22); wr_end(1'b1);
      chk("R6 ovf set", ovf_flag, 1);
      chk("R6 overwrite", cpu_rdata, 8'h22);
      cpu_read();
      chk("R5 read clears", in_full, 0);
      chk("R7 read keeps ovf", ovf_flag, 1);
      @(negedge clk); cpu_ovf_clr = 1'b1; @(negedge clk); cpu_ovf_clr = 1'b0;
      chk("R7 cleared", ovf_flag, 0);

      // R8 host read
      @(negedge clk); cpu_wdata = 8'h3C; cpu_wr_out = 1'b1;
      @(negedge clk); cpu_wr_out = 1'b0;
      chk("R8 latch", ext_data_out, 8'h3C);
      chk("R8 idle oe", ext_data_oe, 0);
      ext_cs_n = 1'b0; ext_rd_n = 1'b0;
      cyc(4);
      chk("R8 oe", ext_data_oe, 1);
      ext_cs_n = 1'b1; ext_rd_n = 1'b1;
      cyc(4);
      chk("R8 release", ext_data_oe, 0);

      // R9 disabled port
      port_en = 1'b0;
      base = irq_cnt;
      wr_begin(8'hF0); wr_end(1'b0);
      chk("R9 no full", in_full, 0);
      chk("R9 no irq", irq_cnt, base);
      chk("R9 no capture", cpu_rdata, 8'h22);
      ext_cs_n = 1'b0; ext_rd_n = 1'b0;
      cyc(4);
      chk("R9 no drive", ext_data_oe, 0);
      ext_cs_n = 1'b1; ext_rd_n = 1'b1;
      cyc(4);
      port_en = 1'b1;
      cyc(2);

      // R10 partial strobes
      base = irq_cnt;
      ext_data_in = 8'h99; ext_wr_n = 1'b0; cyc(5); ext_wr_n = 1'b1; cyc(5);
      ext_cs_n = 1'b0; cyc(5); ext_cs_n = 1'b1; cyc(5);
      chk("R10 no full", in_full, 0);
      chk("R10 no irq", irq_cnt, base);
      chk("R10 latch kept", cpu_rdata, 8'h22);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule